// File: doc/BRIEF.md
# Five-Input Vectored Interrupt Front End

This block sits beside the sequencer of an 8-bit core and decides which interrupt request, if any, the core should take next. It watches five request pins. One of them is non-maskable. Three are restart lines, each with its own mask bit. The fifth is a general request, and for that one the core fetches the instruction from outside. Of the three restart lines, the highest-level one is caught by an edge latch, and the other two follow their pin levels. A global enable gates every request except the non-maskable one.

Software reaches the block through two operations, and each completes in a single clock. A set-mask strobe carries the accumulator byte. It can reload the three masks, drop a pending edge on the highest restart line without servicing it, and update a serial output bit. A read-mask output returns, at any time, the serial input pin, the three pending bits, the global enable and the masks.

On each cycle the block presents the winning request as a source code and a 16-bit vector address. It also raises a wake signal that releases a halted core. The core pulses an accept input when it takes the request. That pulse clears the global enable and the latch of the source that was taken.

Top module: `irq_front`

## Requirements
- R1: After reset all three masks read 1, the global enable reads 0, the serial output is 0, nothing is pending, and `req_o` and `wake_o` are 0. The read-mask value is therefore 0x07 when `sid_i` is low.
- R2: A pulse on `ei_i` sets the global enable and a pulse on `di_i` clears it, in each case from the next cycle. When both are pulsed in the same cycle the enable ends up cleared.
- R3: A set-mask strobe with byte bit 3 high loads the masks from bits 2:0. Bit 2 masks the 7.5 line, bit 1 the 6.5 line and bit 0 the 5.5 line. With bit 3 low the masks keep their values.
- R4: A set-mask strobe with byte bit 6 high loads `sod_o` from bit 7 on the next cycle. With bit 6 low `sod_o` keeps its value.
- R5: A rising edge on `rst75_i` sets the 7.5 pending bit in the next cycle. The bit stays set after the pin falls, and it is set even while that line is masked. A set-mask strobe with bit 4 high clears it, and this clear wins over an edge in the same cycle.
- R6: The 6.5 and 5.5 pending bits follow their pins in the same cycle, and these lines request service only while their pins are high.
- R7: The read-mask byte places `sid_i` in bit 7, the pending bits for 7.5, 6.5 and 5.5 in bits 6, 5 and 4, the global enable in bit 3, and the masks for 7.5, 6.5 and 5.5 in bits 2, 1 and 0.
- R8: Fixed priority, highest first: TRAP (source code 1), 7.5 (2), 6.5 (3), 5.5 (4), INTR (5). Code 0 means no request.
- R9: The vector is 0x0024 for TRAP, 0x003C for 7.5, 0x0034 for 6.5, 0x002C for 5.5, and 0x0000 for INTR or no request.
- R10: With the global enable at 0, or with a line's mask at 1, that line gives no request. TRAP ignores both the enable and the masks.
- R11: TRAP is latched on a rising edge of `trap_i` and requests while the latch is set and the pin is still high. Accepting it clears the latch.
- R12: An accept pulse while `req_o` is high clears the global enable from the next cycle. Accepting the 7.5 line also clears its pending bit. An accept pulse with no request present has no effect.
- R13: `wake_o` is high exactly when a request is presented on `req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable request pin |
| rst75_i | input | 1 | Edge-sensed restart 7.5 pin |
| rst65_i | input | 1 | Level-sensed restart 6.5 pin |
| rst55_i | input | 1 | Level-sensed restart 5.5 pin |
| intr_i | input | 1 | General request, externally supplied instruction |
| sid_i | input | 1 | Serial input bit |
| ei_i | input | 1 | Enable-interrupts pulse |
| di_i | input | 1 | Disable-interrupts pulse |
| sim_i | input | 1 | Set-mask strobe |
| sim_data_i | input | 8 | Accumulator byte for the set-mask operation |
| ack_i | input | 1 | Core accepts the presented request |
| rim_data_o | output | 8 | Read-mask byte |
| sod_o | output | 1 | Serial output bit |
| req_o | output | 1 | A request is presented |
| src_o | output | 3 | Winning source code |
| vec_o | output | 16 | Vector address of the winner |
| wake_o | output | 1 | Release from halt |

## Verification
The assertions watch, on every cycle, several rules that hold at all times. Edges are captured into the latches. An accept always drops the enable, and mask and serial-out updates follow the strobe fields. A presented TRAP always wins. No maskable source is presented while the enable is low, and wake always matches the request. Other behaviour can only be shown by the bench's scenarios:
- the whole priority ladder as sources are added one by one;
- each vector address;
- a 7.5 edge persisting after its pin falls, and clearing when the 7.5 line is accepted;
- the clear winning against a simultaneous edge;
- an accept with nothing presented leaving the enable untouched.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int VEC_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NRST   = 3;

    // set-mask byte fields
    localparam int SIM_SOD_BIT   = 7;
    localparam int SIM_SODEN_BIT = 6;
    localparam int SIM_CLR75_BIT = 4;
    localparam int SIM_MSE_BIT   = 3;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_INTR = 3'd5
    } irq_src_e;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;

    typedef struct packed {
        logic [NRST-1:0] mask;
        logic            ie;
        logic            sod;
    } ctl_s;
endpackage

// File: rtl/irqf_edge_latch.sv
module irqf_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } st_s;

    st_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
        if (clr_i)
            st_d.pend = 1'b0;
        else if (pin_i && !st_q.prev)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R5
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_i && !st_q.prev && !clr_i) |=> pend_o);

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_o);
endmodule

// File: rtl/irqf_ctl.sv
module irqf_ctl
    import irqf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ei_i,
    input  logic            di_i,
    input  logic            take_i,
    input  logic            msk_we_i,
    input  logic [NRST-1:0] msk_val_i,
    input  logic            sod_we_i,
    input  logic            sod_val_i,
    output ctl_s            ctl_o
);
    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ei_i)
            ctl_d.ie = 1'b1;
        if (di_i || take_i)
            ctl_d.ie = 1'b0;
        if (msk_we_i)
            ctl_d.mask = msk_val_i;
        if (sod_we_i)
            ctl_d.sod = sod_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mask <= '1;
            ctl_q.ie   <= 1'b0;
            ctl_q.sod  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;

    // R12
    take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !ctl_o.ie);

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msk_we_i |=> ctl_o.mask == $past(msk_val_i));

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msk_we_i |=> $stable(ctl_o.mask));

    // R4
    sod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sod_we_i |=> $stable(ctl_o.sod));
endmodule

// File: rtl/irqf_arbiter.sv
module irqf_arbiter
    import irqf_pkg::*;
(
    input  logic             trap_i,
    input  logic [NRST-1:0]  pend_i,
    input  logic [NRST-1:0]  mask_i,
    input  logic             intr_i,
    input  logic             ie_i,
    output logic             valid_o,
    output irq_src_e         src_o,
    output logic [VEC_W-1:0] vec_o
);
    logic [NRST-1:0] live;

    always_comb begin
        live  = pend_i & ~mask_i & {NRST{ie_i}};
        src_o = SRC_NONE;
        vec_o = '0;
        if (trap_i) begin
            src_o = SRC_TRAP;
            vec_o = VEC_TRAP;
        end else if (live[2]) begin
            src_o = SRC_R75;
            vec_o = VEC_R75;
        end else if (live[1]) begin
            src_o = SRC_R65;
            vec_o = VEC_R65;
        end else if (live[0]) begin
            src_o = SRC_R55;
            vec_o = VEC_R55;
        end else if (intr_i && ie_i) begin
            src_o = SRC_INTR;
        end
        valid_o = (src_o != SRC_NONE);
    end
endmodule

// File: rtl/irq_front.sv
module irq_front
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_i,
    input  logic              rst75_i,
    input  logic              rst65_i,
    input  logic              rst55_i,
    input  logic              intr_i,
    input  logic              sid_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              sim_i,
    input  logic [BYTE_W-1:0] sim_data_i,
    input  logic              ack_i,
    output logic [BYTE_W-1:0] rim_data_o,
    output logic              sod_o,
    output logic              req_o,
    output logic [2:0]        src_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              wake_o
);
    localparam int NLAT = 2; // index 0: TRAP, index 1: 7.5

    ctl_s            ctl;
    irq_src_e        src;
    logic            take;
    logic            trap_live;
    logic [NRST-1:0] pend;
    logic [NLAT-1:0] lat_pin, lat_clr, lat_q;

    assign take = ack_i && req_o;

    assign lat_pin = {rst75_i, trap_i};
    assign lat_clr[0] = take && (src == SRC_TRAP);
    assign lat_clr[1] = (take && (src == SRC_R75)) ||
                        (sim_i && sim_data_i[SIM_CLR75_BIT]);

    for (genvar g = 0; g < NLAT; g++) begin : g_lat
        irqf_edge_latch u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (lat_pin[g]),
            .clr_i  (lat_clr[g]),
            .pend_o (lat_q[g])
        );
    end

    irqf_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ei_i      (ei_i),
        .di_i      (di_i),
        .take_i    (take),
        .msk_we_i  (sim_i && sim_data_i[SIM_MSE_BIT]),
        .msk_val_i (sim_data_i[NRST-1:0]),
        .sod_we_i  (sim_i && sim_data_i[SIM_SODEN_BIT]),
        .sod_val_i (sim_data_i[SIM_SOD_BIT]),
        .ctl_o     (ctl)
    );

    assign trap_live = lat_q[0] && trap_i;
    assign pend      = {lat_q[1], rst65_i, rst55_i};

    irqf_arbiter u_arb (
        .trap_i  (trap_live),
        .pend_i  (pend),
        .mask_i  (ctl.mask),
        .intr_i  (intr_i),
        .ie_i    (ctl.ie),
        .valid_o (req_o),
        .src_o   (src),
        .vec_o   (vec_o)
    );

    assign src_o      = src;
    assign sod_o      = ctl.sod;
    assign rim_data_o = {sid_i, pend, ctl.ie, ctl.mask};
    assign wake_o     = trap_live ||
                        (ctl.ie && ((|(pend & ~ctl.mask)) || intr_i));

    // R8
    trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q[0] && trap_i) |-> (src_o == SRC_TRAP));

    // R10
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ctl.ie) |-> (src_o == SRC_TRAP));

    // R13
    wake_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o == req_o);

    // R12
    r75_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && src_o == SRC_R75) |=> !rim_data_o[6]);
endmodule

// File: tb/irq_front_tb_top.sv
module irq_front_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, intr_i = 0;
    logic       sid_i = 0, ei_i = 0, di_i = 0, sim_i = 0, ack_i = 0;
    logic [7:0] sim_data_i = '0;
    logic [7:0] rim_data_o;
    logic       sod_o, req_o, wake_o;
    logic [2:0] src_o;
    logic [15:0] vec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_front dut_i (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rst75_i(rst75_i),
        .rst65_i(rst65_i), .rst55_i(rst55_i), .intr_i(intr_i), .sid_i(sid_i),
        .ei_i(ei_i), .di_i(di_i), .sim_i(sim_i), .sim_data_i(sim_data_i),
        .ack_i(ack_i), .rim_data_o(rim_data_o), .sod_o(sod_o), .req_o(req_o),
        .src_o(src_o), .vec_o(vec_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_sim(input logic [7:0] v);
        sim_i = 1'b1; sim_data_i = v;
        step();
        sim_i = 1'b0; sim_data_i = '0;
    endtask

    task automatic pulse_ei();
        ei_i = 1'b1; step(); ei_i = 1'b0;
    endtask

    task automatic pulse_di();
        di_i = 1'b1; step(); di_i = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1; step(); ack_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rim after reset", rim_data_o, 8'h07);
        chk("R1 sod after reset", sod_o, 0);
        chk("R1 req after reset", req_o, 0);
        chk("R1 wake after reset", wake_o, 0);
    endtask

    task automatic t_ei_di();
        pulse_ei();
        chk("R2 ei sets enable", rim_data_o[3], 1);
        pulse_di();
        chk("R2 di clears enable", rim_data_o[3], 0);
        ei_i = 1'b1; di_i = 1'b1; step(); ei_i = 1'b0; di_i = 1'b0;
        chk("R2 di wins over ei", rim_data_o[3], 0);
    endtask

    task automatic t_sim();
        do_sim(8'h0D);
        chk("R3 masks loaded", rim_data_o[2:0], 3'b101);
        do_sim(8'h02);
        chk("R3 masks held without bit3", rim_data_o[2:0], 3'b101);
        do_sim(8'hC0);
        chk("R4 sod set", sod_o, 1);
        do_sim(8'h00);
        chk("R4 sod held without bit6", sod_o, 1);
        do_sim(8'h40);
        chk("R4 sod cleared", sod_o, 0);
    endtask

    task automatic t_r75();
        do_sim(8'h0F);
        rst75_i = 1'b1; step(); rst75_i = 1'b0;
        chk("R5 edge latched while masked", rim_data_o[6], 1);
        chk("R10 masked 7.5 no request", req_o, 0);
        step();
        chk("R5 latch held after pin falls", rim_data_o[6], 1);
        do_sim(8'h10);
        chk("R5 sim clears latch", rim_data_o[6], 0);
        rst75_i = 1'b1; sim_i = 1'b1; sim_data_i = 8'h10; step();
        sim_i = 1'b0; sim_data_i = '0;
        chk("R5 clear wins over edge", rim_data_o[6], 0);
        rst75_i = 1'b0; step();
    endtask

    task automatic t_level();
        rst65_i = 1'b1; #1;
        chk("R6 6.5 pending follows pin", rim_data_o[5], 1);
        rst65_i = 1'b0; rst55_i = 1'b1; #1;
        chk("R6 6.5 pending drops", rim_data_o[5], 0);
        chk("R7 5.5 pending in bit4", rim_data_o[4], 1);
        rst55_i = 1'b0;
        sid_i = 1'b1; #1;
        chk("R7 sid in bit7", rim_data_o[7], 1);
        sid_i = 1'b0;
        do_sim(8'h0D);
        pulse_ei();
        rst65_i = 1'b1; #1;
        chk("R6 6.5 requests while high", req_o, 1);
        chk("R9 6.5 vector", vec_o, 16'h0034);
        rst65_i = 1'b0; #1;
        chk("R6 6.5 request drops with pin", req_o, 0);
        pulse_di();
    endtask

    task automatic t_priority();
        do_sim(8'h08);
        pulse_ei();
        intr_i = 1'b1; #1;
        chk("R8 intr source", src_o, 5);
        chk("R9 intr vector", vec_o, 0);
        rst55_i = 1'b1; #1;
        chk("R8 5.5 over intr", src_o, 4);
        chk("R9 5.5 vector", vec_o, 16'h002C);
        rst65_i = 1'b1; #1;
        chk("R8 6.5 over 5.5", src_o, 3);
        rst75_i = 1'b1; step();
        chk("R8 7.5 over 6.5", src_o, 2);
        chk("R9 7.5 vector", vec_o, 16'h003C);
        trap_i = 1'b1; step();
        chk("R11 trap over all", src_o, 1);
        chk("R9 trap vector", vec_o, 16'h0024);
        pulse_di();
        chk("R10 trap ignores enable", src_o, 1);
        chk("R13 wake on trap", wake_o, 1);
        pulse_ack();
        chk("R11 trap cleared on accept", req_o, 0);
        chk("R13 no wake when disabled", wake_o, 0);
        pulse_ei();
        chk("R8 7.5 after trap", src_o, 2);
        pulse_ack();
        chk("R12 accept clears enable", rim_data_o[3], 0);
        chk("R12 accept clears 7.5 latch", rim_data_o[6], 0);
        pulse_ei();
        chk("R8 6.5 next", src_o, 3);
        do_sim(8'h0A);
        chk("R10 6.5 masked gives 5.5", src_o, 4);
        do_sim(8'h0F);
        chk("R10 all masked gives intr", src_o, 5);
        pulse_di();
        chk("R10 disabled no request", req_o, 0);
        trap_i = 0; rst75_i = 0; rst65_i = 0; rst55_i = 0; intr_i = 0;
        pulse_ei();
        chk("R12 idle enabled no request", req_o, 0);
        pulse_ack();
        chk("R12 accept without request ignored", rim_data_o[3], 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_ei_di();
        t_sim();
        t_r75();
        t_level();
        t_priority();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule